// File: doc/BRIEF.md
# Dual Reloadable Interval Timers

This block provides two up-counting interval timers that sit in a processor's I/O command space. Timer A advances on every rising edge of a slow, free-running timing clock. Timer B advances once for every ten such edges, through a divide-by-ten prescaler that is cleared whenever Timer B is reset. The timing clock is asynchronous to the system clock. It is synchronised, and each of its rising edges becomes one system-clock enable pulse.

Software drives each timer through a one-cycle command strobe. The strobe carries a unit select, an opcode and a data word. With it, software can start or stop a timer, load its count, read its live count, rewrite its reload register, or reset the count from that register. When a count wraps past its all-ones value, the timer takes its count from the reload register and pulses its own interrupt request line for one cycle. A console-hold input freezes both timers and the prescaler while a debug console session is active.

Top module: `dual_interval_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both counts and both reload registers are zero, both timers are stopped, `irq_a` and `irq_b` are low and `rd_data` is zero.
- R2: A running Timer A, with `console_hold` low, adds exactly one to its count for each rising edge of `tclk_in`.
- R3: A running Timer B adds one to its count for every ten rising edges of `tclk_in`. A reset command to Timer B (opcode 6) clears the partial divide-by-ten count, so the next increment comes a full ten edges later.
- R4: Commands take effect only in a cycle where `cmd_valid` is high. `cmd_unit` 0 selects Timer A and 1 selects Timer B. The opcodes are 1 start, 2 stop, 3 load count from `cmd_wdata`, 4 read, 5 write reload register from `cmd_wdata`, and 6 reset count from the reload register. Opcodes 0 and 7 change nothing.
- R5: A read (opcode 4) places the selected timer's live count on `rd_data` in the cycle after the strobe and leaves the count unchanged. `rd_data` holds that value until the next read.
- R6: A stop (opcode 2) freezes the count at its current value. A later start (opcode 1) resumes counting from that value.
- R7: When a step arrives at a count of 0xFFFF, the count becomes the reload value. In the next cycle the timer's own interrupt line (`irq_a` for A, `irq_b` for B) is high for exactly one cycle, and the other timer's line stays low.
- R8: A reset command (opcode 6) sets the count to the reload value. A reload write (opcode 5) changes only the reload register and leaves the count as it was.
- R9: While `console_hold` is high, neither count and not the prescaler advance, whatever `tclk_in` does.
- R10: A start, stop, load or reset command to a timer in the same cycle as that timer's step takes effect, and the step is dropped. A reload write in the same cycle as a wrap does not block the wrap: the count takes the reload value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_in | input | 1 | Asynchronous slow timing clock; rising edges are counted |
| console_hold | input | 1 | High freezes both timers and the prescaler |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_unit | input | 1 | Timer select: 0 = A, 1 = B |
| cmd_op | input | 3 | Command opcode (see R4) |
| cmd_wdata | input | 16 | Data for load and reload-write commands |
| rd_data | output | 16 | Count captured by the last read command |
| irq_a | output | 1 | One-cycle overflow request from Timer A |
| irq_b | output | 1 | One-cycle overflow request from Timer B |

## Verification
A software command and a timing-clock step can land on the same system-clock edge. The bench provokes this by raising `tclk_in` and issuing the strobe exactly two cycles later, so the strobe arrives in the cycle where the synchronised edge pulse is high. A load that collides with a step must produce the loaded value, not the loaded value plus one. A reload write that collides with a wrap must give a count equal to the old reload value and one interrupt pulse, and the new value must appear only at the next reset command. A near-exhaustive sweep of start values just below the wrap point, several reload values and varying numbers of edges is compared against a step-by-step arithmetic model that also counts interrupt pulses.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_START  = 3'd1,
    OP_STOP   = 3'd2,
    OP_LOAD   = 3'd3,
    OP_READ   = 3'd4,
    OP_RELOAD = 3'd5,
    OP_RESET  = 3'd6
  } ivt_op_e;
endpackage

// File: rtl/ivt_edge_tick.sv
module ivt_edge_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic tick
);
  localparam int DEPTH = SYNC_STAGES + 1;
  logic [DEPTH-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[DEPTH-2:0], async_in};
  end

  assign tick = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  logic [PW-1:0] phase;

  assign step = adv && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)  phase <= '0;
    else if (step)     phase <= '0;
    else if (adv)      phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic [2:0]   op,
  input  logic [W-1:0] wdata,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         running,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] reload;
  logic         ctrl;

  assign ctrl = hit && (op == OP_START || op == OP_STOP ||
                        op == OP_LOAD  || op == OP_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      reload  <= '0;
      running <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (hit && op == OP_RELOAD) reload <= wdata;
      if (hit && op == OP_START)  running <= 1'b1;
      if (hit && op == OP_STOP)   running <= 1'b0;
      if (hit && op == OP_LOAD) begin
        count <= wdata;
      end else if (hit && op == OP_RESET) begin
        count <= reload;
      end else if (!ctrl && step && running) begin
        if (count == TOP) begin
          count <= reload;
          ovf   <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import ivt_pkg::*;
#(
  parameter int W           = 16,
  parameter int DIV         = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tclk_in,
  input  logic         console_hold,
  input  logic         cmd_valid,
  input  logic         cmd_unit,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_wdata,
  output logic [W-1:0] rd_data,
  output logic         irq_a,
  output logic         irq_b
);
  localparam int NUM = 2;

  logic         tick, live_tick, pre_step, pre_clear;
  logic [W-1:0] cnt_arr [NUM];
  logic         run_arr [NUM];
  logic         ovf_arr [NUM];
  logic         stp_arr [NUM];
  logic [W-1:0] cnt_a, cnt_b;
  logic         run_a, run_b;

  ivt_edge_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .async_in(tclk_in), .tick(tick)
  );

  assign live_tick = tick && !console_hold;
  assign pre_clear = cmd_valid && cmd_unit && (cmd_op == OP_RESET);

  ivt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(pre_clear),
    .adv(live_tick && run_b), .step(pre_step)
  );

  assign stp_arr[0] = live_tick;
  assign stp_arr[1] = pre_step;

  for (genvar g = 0; g < NUM; g++) begin : g_tmr
    ivt_timer #(.W(W)) u_tmr (
      .clk(clk), .rst(rst),
      .hit(cmd_valid && (cmd_unit == 1'(g))),
      .op(cmd_op), .wdata(cmd_wdata), .step(stp_arr[g]),
      .count(cnt_arr[g]), .running(run_arr[g]), .ovf(ovf_arr[g])
    );
  end

  assign cnt_a = cnt_arr[0];
  assign cnt_b = cnt_arr[1];
  assign run_a = run_arr[0];
  assign run_b = run_arr[1];
  assign irq_a = ovf_arr[0];
  assign irq_b = ovf_arr[1];

  always_ff @(posedge clk) begin
    if (rst)                                  rd_data <= '0;
    else if (cmd_valid && cmd_op == OP_READ)  rd_data <= cmd_unit ? cnt_b : cnt_a;
  end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         console_hold,
  input logic         cmd_valid,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] cnt_b,
  input logic         run_a,
  input logic         irq_a,
  input logic         irq_b
);
  // R7: an interrupt request lasts one cycle
  a_r7_irq_a_single: assert property (@(posedge clk) disable iff (rst)
    irq_a |=> !irq_a);
  a_r7_irq_b_single: assert property (@(posedge clk) disable iff (rst)
    irq_b |=> !irq_b);

  // R7: Timer A requests only after leaving the all-ones count
  a_r7_irq_from_top: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq_a) |-> ($past(cnt_a) == {W{1'b1}}));

  // R9: console hold freezes both counts
  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (console_hold && !cmd_valid) |=> ($stable(cnt_a) && $stable(cnt_b)));

  // R6: a stopped timer keeps its count
  a_r6_stopped_keeps: assert property (@(posedge clk) disable iff (rst)
    (!run_a && !cmd_valid) |=> $stable(cnt_a));

  // R2: without a command or wrap, Timer A moves only by one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmd_valid) && !irq_a && (cnt_a != $past(cnt_a)))
      |-> (cnt_a == $past(cnt_a) + 1'b1));
endmodule

bind dual_interval_timer ivt_checker #(.W(W)) u_ivt_chk (
  .clk(clk), .rst(rst), .console_hold(console_hold), .cmd_valid(cmd_valid),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .run_a(run_a), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tclk_in = 1'b0;
  logic         console_hold = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_unit = 1'b0;
  logic [2:0]   cmd_op = 3'd0;
  logic [W-1:0] cmd_wdata = '0;
  logic [W-1:0] rd_data;
  logic         irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  int irqa_cnt = 0;
  int irqb_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst(rst), .tclk_in(tclk_in), .console_hold(console_hold),
    .cmd_valid(cmd_valid), .cmd_unit(cmd_unit), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b)
  );

  always @(negedge clk) begin
    if (!rst && irq_a) irqa_cnt++;
    if (!rst && irq_b) irqb_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input bit unit, input logic [2:0] op, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_unit = unit; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_wdata = '0;
  endtask

  task automatic rd(input bit unit, output int v);
    cmd(unit, 3'd4, '0);
    v = int'(rd_data);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tclk_in = 1'b1;
      repeat (4) @(negedge clk);
      tclk_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // raise tclk_in so the counted step lands on the same edge as the command
  task automatic pulse_with_cmd(input bit unit, input logic [2:0] op, input logic [W-1:0] d);
    @(negedge clk); tclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_unit = unit; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    tclk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, ia, ib;
    int model, cnt_irq;
    logic [W-1:0] rl [3];
    rl[0] = 16'h0000; rl[1] = 16'h1234; rl[2] = 16'hFFFF;

    repeat (3) @(negedge clk);
    check("R1 irq_a", int'(irq_a), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq_b", int'(irq_b), 0);
    rd(0, v); check("R1 count A", v, 0);
    rd(1, v); check("R1 count B", v, 0);
    pulse(2);
    rd(0, v); check("R1 A stopped after reset", v, 0);

    // R2: counting while running
    cmd(0, 3'd1, '0);
    pulse(5);
    rd(0, v); check("R2 A five edges", v, 5);
    rd(0, v); check("R5 read leaves count", v, 5);

    // R6: stop and resume
    cmd(0, 3'd2, '0);
    pulse(3);
    rd(0, v); check("R6 stopped", v, 5);
    cmd(0, 3'd1, '0);
    pulse(2);
    rd(0, v); check("R6 resumed", v, 7);

    // R4: ignored opcodes and invalid strobe
    cmd(0, 3'd0, 16'h4444);
    cmd(0, 3'd7, 16'h4444);
    @(negedge clk); cmd_op = 3'd3; cmd_wdata = 16'h4444;
    @(negedge clk); cmd_op = 3'd0; cmd_wdata = '0;
    rd(0, v); check("R4 ignored ops", v, 7);
    cmd(0, 3'd3, 16'h0100);
    rd(0, v); check("R4 load", v, 16'h0100);

    // R8: reload write leaves count, reset takes reload
    cmd(0, 3'd5, 16'h0033);
    rd(0, v); check("R8 reload write keeps count", v, 16'h0100);
    cmd(0, 3'd6, '0);
    rd(0, v); check("R8 reset from reload", v, 16'h0033);

    // R10: load collides with step
    pulse_with_cmd(0, 3'd3, 16'h0200);
    rd(0, v); check("R10 load wins over step", v, 16'h0200);

    // R10: reload write collides with wrap
    cmd(0, 3'd5, 16'h0005);
    cmd(0, 3'd3, 16'hFFFF);
    ia = irqa_cnt;
    pulse_with_cmd(0, 3'd5, 16'h0009);
    rd(0, v); check("R10 wrap uses old reload", v, 5);
    check("R10 one irq on collision", irqa_cnt - ia, 1);
    cmd(0, 3'd6, '0);
    rd(0, v); check("R10 new reload after reset", v, 9);

    // R7 sweep near the wrap point against an arithmetic model
    for (int r = 0; r < 3; r++) begin
      cmd(0, 3'd5, rl[r]);
      for (int s = 16'hFFFA; s <= 16'hFFFF; s++) begin
        for (int n = 1; n <= 4; n++) begin
          cmd(0, 3'd3, W'(s));
          ia = irqa_cnt; ib = irqb_cnt;
          pulse(n);
          model = s; cnt_irq = 0;
          for (int k = 0; k < n; k++) begin
            if (model == 16'hFFFF) begin model = int'(rl[r]); cnt_irq++; end
            else model = model + 1;
          end
          rd(0, v);
          check("R7 sweep count", v, model);
          check("R7 sweep irq_a", irqa_cnt - ia, cnt_irq);
          check("R7 no irq_b", irqb_cnt - ib, 0);
        end
      end
    end
    cmd(0, 3'd2, '0);

    // R3: Timer B divide by ten
    cmd(1, 3'd1, '0);
    pulse(10);
    rd(1, v); check("R3 B after ten", v, 1);
    pulse(9);
    rd(1, v); check("R3 B after nineteen", v, 1);
    pulse(1);
    rd(1, v); check("R3 B after twenty", v, 2);
    pulse(5);
    cmd(1, 3'd6, '0);
    rd(1, v); check("R3 B reset to reload", v, 0);
    pulse(9);
    rd(1, v); check("R3 prescaler cleared nine", v, 0);
    pulse(1);
    rd(1, v); check("R3 prescaler cleared ten", v, 1);

    // R7 on Timer B
    cmd(1, 3'd5, 16'h0042);
    cmd(1, 3'd3, 16'hFFFF);
    cmd(1, 3'd6, '0);
    cmd(1, 3'd3, 16'hFFFF);
    ia = irqa_cnt; ib = irqb_cnt;
    pulse(10);
    rd(1, v); check("R7 B wrap to reload", v, 16'h0042);
    check("R7 B irq pulse", irqb_cnt - ib, 1);
    check("R7 A quiet", irqa_cnt - ia, 0);

    // R9: console hold
    cmd(0, 3'd3, 16'h0010);
    cmd(0, 3'd1, '0);
    cmd(1, 3'd6, '0);
    @(negedge clk); console_hold = 1'b1;
    pulse(12);
    rd(0, v); check("R9 A frozen", v, 16'h0010);
    rd(1, v); check("R9 B frozen", v, 16'h0042);
    @(negedge clk); console_hold = 1'b0;
    pulse(9);
    rd(1, v); check("R9 prescaler frozen nine", v, 16'h0042);
    pulse(1);
    rd(1, v); check("R9 prescaler frozen ten", v, 16'h0043);
    rd(0, v); check("R9 A resumes", v, 16'h001A);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule